// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and a 64K x 4 asynchronous static RAM. It turns one single-word read or write request into the chip-enable, write-enable and output-enable strobe sequence that the memory needs. The host raises `req` for one cycle while `busy` is low, with `wr`, `addr` and `wdata`. The block answers with a one-cycle `done` pulse. After a read, the word is held on `rdata`.

Timing limits are given in picoseconds with the clock period. The block rounds each limit up to whole cycles to set its phase lengths.
- During a write it keeps output enable high. It holds its own data drivers off for a turnaround count after write enable falls, then drives the data for at least the setup time before write enable rises.
- During a read it keeps chip enable and output enable low for the access-wait count, then captures the data bus.
- Between requests chip enable is high, which puts the memory in standby.

The data pins are split into `mem_dq_o`, `mem_dq_i` and `mem_dq_oe`. A pad cell outside this block joins them into the bidirectional pins.

Top module: `asram_ctl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe`, `busy` and `done` are 0. Asserting reset in the middle of a write returns all strobes to these values.
- R2: Whenever `busy` is 0, `mem_ce_n` is 1 (standby), `mem_we_n` is 1 and `mem_dq_oe` is 0.
- R3: A request is accepted only in a cycle where `req` is 1 and `busy` is 0. A request raised while `busy` is 1 is ignored and never reaches the memory.
- R4: A write holds chip enable low for one cycle with write enable high. It then holds write enable low for WE_CYC cycles, then holds write enable high with chip enable still low for one cycle. Output enable stays high throughout.
- R5: During the write-enable-low phase, `mem_dq_oe` is 0 for the first TURN_CYC cycles and 1 for the remaining cycles. It stays 1 in the cycle after write enable rises. It is never 1 while `mem_oe_n` is 0 or `mem_ce_n` is 1.
- R6: `mem_addr` and `mem_dq_o` take the host's address and data at acceptance. They do not change while chip enable remains low.
- R7: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for ACC_CYC cycles. It loads `mem_dq_i` into `rdata` on the clock edge that ends that phase.
- R8: `done` is a one-cycle pulse in the first cycle that `busy` is 0 again. It comes 2+WE_CYC clock edges after the accepting edge for a write, and ACC_CYC edges after it for a read.
- R9: TURN_CYC = ceil(T_HZ_PS/CLK_PS). WE_CYC = max(ceil(T_PWE_PS/CLK_PS), TURN_CYC + max(1, ceil(T_SD_PS/CLK_PS))). ACC_CYC = max(1, ceil(T_AA_PS/CLK_PS)).
- R10: `rdata` changes only when a read completes; writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, sampled while busy is low |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW (16) | Word address |
| wdata | input | DW (4) | Write data |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW (4) | Last word read |
| mem_addr | output | AW (16) | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | DW (4) | Data toward the memory |
| mem_dq_i | input | DW (4) | Data from the memory |
| mem_dq_oe | output | 1 | Enable for the data pad drivers |

## Verification
The properties assume that `rst` is applied from time zero, and that the host holds `req`, `wr`, `addr` and `wdata` steady around each clock edge. The stimulus changes every input only on the falling clock edge. It raises `req` both while idle and while busy, so that the properties on acceptance and standby see both cases. The memory model in the bench drives `mem_dq_i` only while chip enable and output enable are low and write enable is high. It stores a word only from the last write-enable-low cycle. This stays within what the properties take for granted about the memory's behaviour.

// File: rtl/asram_ctl.sv
module asram_ctl #(
  parameter int AW        = 16,
  parameter int DW        = 4,
  parameter int CLK_PS    = 20000,
  parameter int T_AA_PS   = 12000,
  parameter int T_PWE_PS  = 8000,
  parameter int T_SD_PS   = 7000,
  parameter int T_HZ_PS   = 6000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_o,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_dq_oe
);
  localparam int TURN_CYC = (T_HZ_PS + CLK_PS - 1) / CLK_PS;
  localparam int SD_RAW   = (T_SD_PS + CLK_PS - 1) / CLK_PS;
  localparam int SD_CYC   = (SD_RAW < 1) ? 1 : SD_RAW;
  localparam int PWE_CYC  = (T_PWE_PS + CLK_PS - 1) / CLK_PS;
  localparam int WE_CYC   = (PWE_CYC > TURN_CYC + SD_CYC) ? PWE_CYC : TURN_CYC + SD_CYC;
  localparam int ACC_RAW  = (T_AA_PS + CLK_PS - 1) / CLK_PS;
  localparam int ACC_CYC  = (ACC_RAW < 1) ? 1 : ACC_RAW;
  localparam int MAXC     = (WE_CYC > ACC_CYC) ? WE_CYC : ACC_CYC;
  localparam int CW       = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_WSET, S_WLOW, S_WHLD, S_RACC} st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          accept, fin, rd_fin;

  assign busy   = (st != S_IDLE);
  assign accept = (st == S_IDLE) && req;
  assign rd_fin = (st == S_RACC) && (cnt == CW'(ACC_CYC - 1));
  assign fin    = (st == S_WHLD) || rd_fin;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    case (st)
      S_IDLE: if (req) begin
        st_nx  = wr ? S_WSET : S_RACC;
        cnt_nx = '0;
      end
      S_WSET: begin
        st_nx  = S_WLOW;
        cnt_nx = '0;
      end
      S_WLOW: if (cnt == CW'(WE_CYC - 1)) begin
        st_nx  = S_WHLD;
        cnt_nx = '0;
      end else begin
        cnt_nx = cnt + 1'b1;
      end
      S_WHLD: st_nx = S_IDLE;
      S_RACC: if (rd_fin) begin
        st_nx  = S_IDLE;
        cnt_nx = '0;
      end else begin
        cnt_nx = cnt + 1'b1;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      done      <= 1'b0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rdata     <= '0;
    end else begin
      st        <= st_nx;
      cnt       <= cnt_nx;
      mem_ce_n  <= (st_nx == S_IDLE);
      mem_we_n  <= (st_nx != S_WLOW);
      mem_oe_n  <= (st_nx != S_RACC);
      mem_dq_oe <= ((st_nx == S_WLOW) && ({1'b0, cnt_nx} >= (CW+1)'(TURN_CYC))) || (st_nx == S_WHLD);
      done      <= fin;
      if (accept) begin
        mem_addr <= addr;
        mem_dq_o <= wdata;
      end
      if (rd_fin) rdata <= mem_dq_i;
    end
  end
endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk #(
  parameter int AW = 16,
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_o
);
  a_r2_standby_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mem_ce_n && mem_we_n && !mem_dq_oe));

  a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  a_r4_ce_leads_we: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(!mem_ce_n));

  a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

  a_r5_setup_and_hold: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_we_n) && !mem_ce_n) |-> (mem_dq_oe && $past(mem_dq_oe)));

  a_r6_bus_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

  a_r7_read_strobes: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind asram_ctl asram_ctl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o)
);

// File: tb/asram_ctl_tb.sv
`timescale 1ns/1ps
module asram_ctl_tb;
  localparam int CLK_PS = 20000;
  localparam int TURN   = (6000 + CLK_PS - 1) / CLK_PS;
  localparam int SDC    = ((7000 + CLK_PS - 1) / CLK_PS < 1) ? 1 : (7000 + CLK_PS - 1) / CLK_PS;
  localparam int PWEC   = (8000 + CLK_PS - 1) / CLK_PS;
  localparam int WEC    = (PWEC > TURN + SDC) ? PWEC : TURN + SDC;
  localparam int ACC    = ((12000 + CLK_PS - 1) / CLK_PS < 1) ? 1 : (12000 + CLK_PS - 1) / CLK_PS;
  localparam int NV     = 11;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 16'h0000, 4'h5, 4'h0},
    {1'b1, 16'hFFFF, 4'hA, 4'h0},
    {1'b1, 16'h1234, 4'h3, 4'h0},
    {1'b0, 16'hFFFF, 4'h0, 4'hA},
    {1'b0, 16'h0000, 4'h0, 4'h5},
    {1'b1, 16'h1234, 4'hC, 4'h0},
    {1'b0, 16'h1234, 4'h0, 4'hC},
    {1'b0, 16'h00FF, 4'h0, 4'h0},
    {1'b1, 16'h8001, 4'hF, 4'h0},
    {1'b0, 16'h8001, 4'h0, 4'hF},
    {1'b0, 16'h1234, 4'h0, 4'hC}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0;
  logic [3:0]  wdata = '0;
  logic        busy, done, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [3:0]  rdata, mem_dq_o;
  logic [3:0]  mem_dq_i = '0;
  logic [15:0] mem_addr;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  asram_ctl u_dut (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .rdata(rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe)
  );

  logic [3:0]  model [int];
  logic        wlow = 0, wdrv = 0, drv_err = 0;
  logic [15:0] waddr = '0;
  logic [3:0]  wdat = '0;
  int          wk = 0;

  always @(negedge clk) begin
    if (rst) begin
      wlow <= 0; wk <= 0; drv_err <= 0;
    end else if (!mem_ce_n && !mem_we_n) begin
      if (!wlow) begin wk <= 1; drv_err <= (mem_dq_oe != (0 >= TURN)); end
      else begin wk <= wk + 1; if (mem_dq_oe != (wk >= TURN)) drv_err <= 1; end
      wlow <= 1; waddr <= mem_addr; wdat <= mem_dq_o; wdrv <= mem_dq_oe;
    end else if (wlow) begin
      if (!wdrv || !mem_dq_oe) drv_err <= 1;
      model[int'(waddr)] = wdat;
      wlow <= 0;
    end
    if (!mem_ce_n && mem_we_n && !mem_oe_n)
      mem_dq_i <= model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 4'h0;
    else
      mem_dq_i <= 4'h0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic op(input bit w, input logic [15:0] a, input logic [3:0] d, input logic [3:0] e);
    int lat;
    logic [3:0] rd_before;
    rd_before = rdata;
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    lat = 0;
    while (!done && !finished) begin
      @(negedge clk);
      lat++;
    end
    if (w) begin
      chk(lat == 2 + WEC, "R8 R9 write latency", lat, 2 + WEC);
      chk(wk == WEC && !drv_err, "R4 R5 write strobe shape", wk, WEC);
      chk(rdata == rd_before, "R10 rdata kept over write", rdata, rd_before);
    end else begin
      chk(lat == ACC, "R8 R9 read latency", lat, ACC);
      chk(rdata == e, "R7 read data", rdata, e);
    end
    @(negedge clk);
    chk(!done && !busy && mem_ce_n, "R2 R8 idle after done", {done, busy, mem_ce_n}, 3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !done, "R1 reset state",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, busy, done}, 6'b111000);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy, "R1 first cycle out of reset",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, busy}, 5'b11100);

    for (int i = 0; i < NV; i++)
      op(VEC[i][24], VEC[i][23:8], VEC[i][7:4], VEC[i][3:0]);

    repeat (3) @(negedge clk);
    chk(mem_ce_n && !busy, "R2 standby while idle", {mem_ce_n, busy}, 2'b10);

    // R3: request while busy is dropped
    req = 1'b1; wr = 1'b1; addr = 16'h0040; wdata = 4'h6;
    @(negedge clk);
    addr = 16'h0041; wdata = 4'h9;
    @(negedge clk);
    chk(mem_addr == 16'h0040 && mem_dq_o == 4'h6, "R3 R6 busy request not taken",
        {mem_addr, mem_dq_o}, {16'h0040, 4'h6});
    @(negedge clk);
    req = 1'b0;
    while (!done && !finished) @(negedge clk);
    @(negedge clk);
    op(1'b0, 16'h0041, 4'h0, 4'h0);
    op(1'b0, 16'h0040, 4'h0, 4'h6);
    chk(!model.exists(32'h41), "R3 ignored write absent from memory", model.exists(32'h41), 0);

    // R1: reset in the middle of a write
    req = 1'b1; wr = 1'b1; addr = 16'h0100; wdata = 4'h7;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    chk(!mem_we_n, "R4 write enable low mid-write", mem_we_n, 0);
    rst = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy, "R1 reset aborts write",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, busy}, 5'b11100);
    rst = 1'b0;
    @(negedge clk);
    op(1'b1, 16'h0100, 4'h2, 4'h0);
    op(1'b0, 16'h0100, 4'h0, 4'h2);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule